// File: doc/BRIEF.md
# Two-Stage Serial Bit-Rate Tick Generator

This block derives the timing strobes for a serial transmitter and receiver from one reference clock. An optional fixed divide-by-8 stage comes first. It is built as a clock-enable pulse, so the whole block stays on the single input clock. A 16-bit clock-divisor counter follows and produces a sample tick. An 8-bit bit-divisor counter then groups those sample ticks into bit periods. The resulting bit rate is the selected clock divided by CD times (BDIV + 1). The selected clock is either the reference clock or the reference clock divided by 8.

The divisors and the prescaler select are plain level inputs. Software or a host block outside this one computes them from the requested baud rate. The block keeps a registered copy of its settings. When any setting differs from that copy, both counters restart from zero on the next clock edge. The new timing therefore starts from a clean phase. Divisor values should only be changed while the transmitter and receiver are idle, because the restart cuts off any bit period in progress.

Top module: `baud_tick_gen`

## Requirements
- R1: With the prescaler off (`prescale_sel` = 0) and CD >= 2, `sample_tick` pulses once every CD clock cycles.
- R2: With the prescaler on (`prescale_sel` = 1) and CD >= 2, `sample_tick` pulses once every 8*CD clock cycles.
- R3: `bit_tick` is high only together with `sample_tick`, on every (BDIV+1)-th sample tick. Its period is therefore (BDIV+1)*CD*P cycles, where P is 1 or 8. Every BDIV value from 0 to 255 is honoured.
- R4: `sample_tick` and `bit_tick` are single-cycle pulses.
- R5: A CD value of 0 or 1 holds both `sample_tick` and `bit_tick` low.
- R6: When any of `cd_val`, `bdiv_val` or `prescale_sel` changes, the next clock edge clears both counters and both ticks. The first sample tick under the new setting then comes CD*P cycles after that edge, and the first bit tick comes (BDIV+1)*CD*P cycles after it.
- R7: While the synchronous active-high reset `rst` is asserted, both ticks are low. The first sample tick comes CD*P cycles after the last reset edge.
- R8: The whole 16-bit CD range is usable: CD = 65535 gives a sample period of 65535 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| cd_val | input | 16 | Clock divisor CD (2 to 65535 to run) |
| bdiv_val | input | 8 | Bit divisor BDIV; a bit lasts BDIV+1 sample ticks |
| prescale_sel | input | 1 | 1 selects the divide-by-8 prescaler |
| sample_tick | output | 1 | One-cycle strobe at the sample rate |
| bit_tick | output | 1 | One-cycle strobe at the bit rate |

## Verification
The bench sweeps small CD values with BDIV 0, 1 and 4, each with and without the prescaler. For every case it compares each output cycle against the arithmetic expectation, starting from the cycle of the change. This catches an off-by-one in the divisor compare, which would stretch or shrink each period by one cycle, and a missing restart, which would leave the old phase running into the new setting. CD values of 0 and 1 are driven to expose a counter that wraps or underflows and ticks anyway. BDIV = 255 and CD = 65535 are driven to catch a counter or comparator cut short by one bit. A reset in the middle of a run checks that ticks are suppressed and that the count starts again from the reset edge.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

  // Prescaler selection as decoded from the select input.
  typedef enum logic {
    PRE_BYPASS = 1'b0,
    PRE_DIVIDE = 1'b1
  } pre_mode_e;

  // Smallest clock divisor that produces sample ticks.
  localparam int unsigned CD_MIN_RUN = 2;

  // Width needed to count 0 .. n-1 (at least one bit).
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/baud_cfg_track.sv
module baud_cfg_track
  import baud_tick_pkg::*;
#(
  parameter int unsigned CD_W = 16,
  parameter int unsigned BD_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CD_W-1:0] cd_in,
  input  logic [BD_W-1:0] bd_in,
  input  logic            pre_in,
  output logic [CD_W-1:0] cd_q,
  output logic [BD_W-1:0] bd_q,
  output pre_mode_e       pre_q,
  output logic            restart
);

  // A setting that differs from the held copy clears the counters on the
  // same edge that takes the new copy.
  assign restart = !rst &&
                   ((cd_in != cd_q) || (bd_in != bd_q) || (pre_in != pre_q));

  always_ff @(posedge clk) begin
    cd_q  <= cd_in;
    bd_q  <= bd_in;
    pre_q <= pre_mode_e'(pre_in);
  end

endmodule

// File: rtl/baud_prescale.sv
module baud_prescale
  import baud_tick_pkg::*;
#(
  parameter int unsigned PRE_DIV = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      clr,
  input  pre_mode_e mode,
  output logic      step
);

  generate
    if (PRE_DIV > 1) begin : g_div
      localparam int unsigned PW = cnt_width(PRE_DIV);
      localparam logic [PW-1:0] PRE_LAST = PW'(PRE_DIV - 1);
      logic [PW-1:0] pre_cnt;

      always_ff @(posedge clk) begin
        if (rst || clr) begin
          pre_cnt <= '0;
        end else if (pre_cnt == PRE_LAST) begin
          pre_cnt <= '0;
        end else begin
          pre_cnt <= pre_cnt + 1'b1;
        end
      end

      // Clock enable: every cycle when bypassed, once per PRE_DIV otherwise.
      assign step = (mode == PRE_BYPASS) || (pre_cnt == PRE_LAST);
    end else begin : g_none
      logic unused_in;
      assign unused_in = clk ^ rst ^ clr ^ mode;
      assign step = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/baud_cd_div.sv
module baud_cd_div
  import baud_tick_pkg::*;
#(
  parameter int unsigned CD_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            step,
  input  logic [CD_W-1:0] cd,
  output logic            wrap,
  output logic            tick
);

  logic [CD_W-1:0] cd_cnt;
  logic            cd_ok;

  assign cd_ok = (cd >= CD_W'(CD_MIN_RUN));
  assign wrap  = step && cd_ok && (cd_cnt == cd - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cd_cnt <= '0;
      tick   <= 1'b0;
    end else begin
      tick <= wrap;
      if (wrap) begin
        cd_cnt <= '0;
      end else if (step && cd_ok) begin
        cd_cnt <= cd_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/baud_bit_div.sv
module baud_bit_div #(
  parameter int unsigned BD_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            adv,
  input  logic [BD_W-1:0] bdiv,
  output logic            tick
);

  logic [BD_W-1:0] bd_cnt;

  // Advances on the same edge as the sample tick register, so the bit tick
  // lands on the sample tick that closes a bit period.
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      bd_cnt <= '0;
      tick   <= 1'b0;
    end else if (adv) begin
      if (bd_cnt == bdiv) begin
        bd_cnt <= '0;
        tick   <= 1'b1;
      end else begin
        bd_cnt <= bd_cnt + 1'b1;
        tick   <= 1'b0;
      end
    end else begin
      tick <= 1'b0;
    end
  end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int unsigned CD_W    = 16,
  parameter int unsigned BD_W    = 8,
  parameter int unsigned PRE_DIV = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [15:0]     cd_val,
  input  logic [7:0]      bdiv_val,
  input  logic            prescale_sel,
  output logic            sample_tick,
  output logic            bit_tick
);

  logic [CD_W-1:0] cd_q;
  logic [BD_W-1:0] bd_q;
  pre_mode_e       pre_q;
  logic            restart;
  logic            step;
  logic            cd_wrap;

  baud_cfg_track #(.CD_W(CD_W), .BD_W(BD_W)) cfg_i (
    .clk     (clk),
    .rst     (rst),
    .cd_in   (CD_W'(cd_val)),
    .bd_in   (BD_W'(bdiv_val)),
    .pre_in  (prescale_sel),
    .cd_q    (cd_q),
    .bd_q    (bd_q),
    .pre_q   (pre_q),
    .restart (restart)
  );

  baud_prescale #(.PRE_DIV(PRE_DIV)) pre_i (
    .clk  (clk),
    .rst  (rst),
    .clr  (restart),
    .mode (pre_q),
    .step (step)
  );

  baud_cd_div #(.CD_W(CD_W)) cd_i (
    .clk  (clk),
    .rst  (rst),
    .clr  (restart),
    .step (step),
    .cd   (cd_q),
    .wrap (cd_wrap),
    .tick (sample_tick)
  );

  baud_bit_div #(.BD_W(BD_W)) bd_i (
    .clk  (clk),
    .rst  (rst),
    .clr  (restart),
    .adv  (cd_wrap),
    .bdiv (bd_q),
    .tick (bit_tick)
  );

endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] cd_val,
  input logic [7:0]  bdiv_val,
  input logic        prescale_sel,
  input logic        sample_tick,
  input logic        bit_tick
);

  AST_BIT_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> sample_tick); // R3

  AST_SAMPLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    sample_tick |=> !sample_tick); // R4

  AST_BIT_PULSE: assert property (@(posedge clk) disable iff (rst)
    bit_tick |=> !bit_tick); // R4

  AST_SMALL_CD_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($past(cd_val) < 16'd2) |=> !sample_tick && !bit_tick); // R5

  AST_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !$stable({cd_val, bdiv_val, prescale_sel}) |=> !sample_tick && !bit_tick); // R6

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !sample_tick && !bit_tick); // R7

endmodule

bind baud_tick_gen baud_tick_gen_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .cd_val       (cd_val),
  .bdiv_val     (bdiv_val),
  .prescale_sel (prescale_sel),
  .sample_tick  (sample_tick),
  .bit_tick     (bit_tick)
);

// File: tb/baud_tick_gen_tb_top.sv
module baud_tick_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cd_val = 16'd4;
  logic [7:0]  bdiv_val = 8'd1;
  logic        prescale_sel = 1'b0;
  logic        sample_tick;
  logic        bit_tick;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  baud_tick_gen dut_i (
    .clk          (clk),
    .rst          (rst),
    .cd_val       (cd_val),
    .bdiv_val     (bdiv_val),
    .prescale_sel (prescale_sel),
    .sample_tick  (sample_tick),
    .bit_tick     (bit_tick)
  );

  always @(posedge clk) cycles <= cycles + 1;

  initial begin
    wait (cycles >= 190000);
    errors = errors + 1;
    $display("FAIL watchdog: run hung, actual %0d cycles expected < 190000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // Observe ncyc cycles; k = c - off counts edges since the clearing edge.
  task automatic observe(input int cd, input int bd, input int sel,
                         input int ncyc, input int off, input string tag);
    int per_s;
    int per_b;
    int bad_s;
    int bad_b;
    int act_s;
    int exp_s;
    int act_b;
    int exp_b;
    per_s = cd * (sel ? 8 : 1);
    per_b = per_s * (bd + 1);
    bad_s = -1;
    bad_b = -1;
    act_s = 0; exp_s = 0; act_b = 0; exp_b = 0;
    for (int c = 1; c <= ncyc; c++) begin
      int k;
      logic es;
      logic eb;
      @(negedge clk);
      k  = c - off;
      es = (cd >= 2) && (k > 0) && (k % per_s == 0);
      eb = (cd >= 2) && (k > 0) && (k % per_b == 0);
      if (bad_s < 0 && sample_tick !== es) begin
        bad_s = k; act_s = sample_tick; exp_s = es;
      end
      if (bad_b < 0 && bit_tick !== eb) begin
        bad_b = k; act_b = bit_tick; exp_b = eb;
      end
    end
    checks = checks + 2;
    if (bad_s >= 0) begin
      errors = errors + 1;
      $display("FAIL %s sample_tick cd=%0d bd=%0d sel=%0d at edge %0d: actual %0d expected %0d",
               tag, cd, bd, sel, bad_s, act_s, exp_s);
    end
    if (bad_b >= 0) begin
      errors = errors + 1;
      $display("FAIL %s bit_tick cd=%0d bd=%0d sel=%0d at edge %0d: actual %0d expected %0d",
               tag, cd, bd, sel, bad_b, act_b, exp_b);
    end
  endtask

  // Change settings mid-run; the following edge restarts the counters.
  task automatic apply(input int cd, input int bd, input int sel,
                       input int ncyc, input string tag);
    @(negedge clk);
    cd_val       = 16'(cd);
    bdiv_val     = 8'(bd);
    prescale_sel = sel[0];
    observe(cd, bd, sel, ncyc, 1, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks = checks + 1;  // R7 reset state
    if (sample_tick !== 1'b0 || bit_tick !== 1'b0) begin
      errors = errors + 1;
      $display("FAIL R7 reset state: actual %0b%0b expected 00", sample_tick, bit_tick);
    end
    rst = 1'b0;
    observe(4, 1, 0, 40, 0, "R7");

    // Sweep: R1 (prescaler off), R2 (on), R3 bit grouping, R6 restart.
    for (int sel = 0; sel < 2; sel++) begin
      for (int cd = 2; cd <= 6; cd++) begin
        for (int bi = 0; bi < 3; bi++) begin
          int bd;
          int len;
          bd  = (bi == 0) ? 0 : ((bi == 1) ? 1 : 4);
          len = 2 * cd * (sel ? 8 : 1) * (bd + 1) + 3;
          apply(cd, bd, sel, len, sel ? "R2_R3_R4_R6" : "R1_R3_R4_R6");
        end
      end
    end

    // R6: change while a long bit period is in progress.
    apply(7, 9, 0, 30, "R6");
    apply(3, 2, 1, 160, "R6");

    // R5: divisors too small to run.
    apply(0, 1, 0, 100, "R5");
    apply(1, 0, 0, 100, "R5");
    apply(1, 0, 1, 100, "R5");

    // R3 upper bit divisor.
    apply(2, 255, 0, 1030, "R3");

    // R7: reset in the middle of a run.
    apply(5, 2, 0, 23, "R7");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    checks = checks + 1;
    if (sample_tick !== 1'b0 || bit_tick !== 1'b0) begin
      errors = errors + 1;
      $display("FAIL R7 ticks during reset: actual %0b%0b expected 00", sample_tick, bit_tick);
    end
    rst = 1'b0;
    observe(5, 2, 0, 80, 0, "R7");

    // R8: largest clock divisor.
    apply(65535, 0, 0, 65538, "R8");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule